// File: doc/BRIEF.md
# ISA Cycle Wait-State Controller

This block runs the command phase of 8-bit and 16-bit memory and I/O cycles on a narrow expansion bus. A divider in the block derives the bus clock from the host clock at one quarter of its rate. All bus activity is timed by a one-host-clock enable pulse that lines up with each rising edge of the bus clock, so the whole block stays in a single clock domain.

The host places a request with its type, width, address and write data, and holds it until the block returns a one-clock acknowledge. When the next bus clock edge arrives, the controller drives the active-low command strobe that matches the request. From the edge after that, it samples two slave inputs on every bus clock edge: an active-low shortening request and an active-high ready. With these it ends the cycle early, at the default length, or late. Ready low always holds the strobe, and it also overrides a shortening request seen on the same edge. A stall counter ends a cycle that is held too long and flags an error with the acknowledge. A separate bus reset input keeps the data bus released and the strobes idle, and the divider keeps running through it.

Top module: `isa_cycle_ctl`

## Requirements
- R1: `bus_clk` has a period of four `clk` cycles, high for two and low for two, and it keeps toggling while `bus_rst` is high.
- R2: A 16-bit memory cycle (`req_mem`=1, `req_wide`=1) whose slave drives `zws_n` low, with `chrdy` high, holds its strobe low for exactly 2 bus clocks.
- R3: An 8-bit cycle (`req_wide`=0), either memory or I/O, whose slave drives `zws_n` low, with `chrdy` high, holds its strobe low for exactly 3 bus clocks.
- R4: A 16-bit I/O cycle (`req_mem`=0, `req_wide`=1) ignores `zws_n` and holds its strobe low for 3 bus clocks.
- R5: With `zws_n` high and `chrdy` high, the strobe stays low for 3 bus clocks on 16-bit memory, 6 on 8-bit memory and 8-bit I/O, and 3 on 16-bit I/O.
- R6: At each bus clock edge where `chrdy` is sampled low, the cycle does not end, even if `zws_n` is low on that edge. The cycle ends on the first later edge where `chrdy` is high and the R2 to R5 length has been reached.
- R7: `zws_n` is sampled only while a strobe is low. A shortening request that is present only while the bus is idle leaves the cycle at its default length.
- R8: When `chrdy` has been sampled low on TMO_BCLK (default 16) edges within one cycle, the cycle ends on that edge and `ack_err` is high with `ack`.
- R9: `ack` is high for exactly one `clk` cycle, starting right after the edge on which the strobe rises. On reads, `ack_rdata` holds `sd_in` as sampled on that edge. `ack_err` is 0 unless R8 applies.
- R10: Exactly one strobe is active per cycle: `memr_n` for memory read, `memw_n` for memory write, `ior_n` for I/O read, `iow_n` for I/O write (`req_write`=1 means write). While the strobe is low, `bus_addr` shows the request address. During writes `sd_oe` is high and `sd_out` shows the write data.
- R11: While `bus_rst` is high, `sd_oe` is low and all strobes are high. A cycle that is running when `bus_rst` rises is dropped with no `ack`.
- R12: After `rst_n` is released, all strobes are high, and `ack` and `sd_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset, synchronous, active high |
| req | input | 1 | Cycle request, held until ack |
| req_mem | input | 1 | 1 memory, 0 I/O |
| req_wide | input | 1 | 1 16-bit, 0 8-bit |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Cycle address |
| req_wdata | input | DW | Write data |
| ack | output | 1 | One-clock cycle completion |
| ack_err | output | 1 | Ready timeout, valid with ack |
| ack_rdata | output | DW | Read data, valid with ack |
| bus_clk | output | 1 | Bus clock, clk divided by four |
| bus_addr | output | AW | Bus address |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| ior_n | output | 1 | I/O read strobe, active low |
| iow_n | output | 1 | I/O write strobe, active low |
| zws_n | input | 1 | Slave shortening request, active low |
| chrdy | input | 1 | Slave ready, high when ready |
| sd_in | input | DW | Data bus input |
| sd_out | output | DW | Data bus output |
| sd_oe | output | 1 | Data bus output enable |

## Verification
Any fault in the elapsed-clock counter, the length selection or the shortening qualification shows up as a strobe pulse that is wrong by a whole number of bus clocks, at the end of the very cycle it affects. A stall counter that is not cleared between cycles shows up as a false `ack_err` in a later stretched cycle. A latched cycle type that gets corrupted drives the wrong strobe on the first bus edge of the cycle. A divider fault changes the `bus_clk` pulse width within four host clocks.

// File: rtl/isa_cyc_pkg.sv
package isa_cyc_pkg;
  typedef enum logic {ST_IDLE, ST_CMD} cyc_state_e;

  typedef struct packed {
    logic mem;
    logic wide;
    logic write;
  } cyc_kind_t;
endpackage

// File: rtl/isa_bclk_div.sv
module isa_bclk_div #(
  parameter int DIV_LOG2 = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic bus_clk,
  output logic tick
);
  localparam logic [DIV_LOG2-1:0] TICK_AT = DIV_LOG2'((1 << (DIV_LOG2 - 1)) - 1);

  logic [DIV_LOG2-1:0] cnt_q, cnt_d;

  always_comb cnt_d = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // bus_clk rises on the edge that follows a tick cycle
  assign bus_clk = cnt_q[DIV_LOG2-1];
  assign tick    = (cnt_q == TICK_AT);
endmodule

// File: rtl/isa_len_sel.sv
module isa_len_sel
  import isa_cyc_pkg::*;
#(
  parameter int CW        = 5,
  parameter int LEN_M16   = 3,
  parameter int LEN_X8    = 6,
  parameter int LEN_IO16  = 3,
  parameter int SHORT_M16 = 2,
  parameter int SHORT_X8  = 3
) (
  input  cyc_kind_t         kind,
  output logic [CW-1:0]     def_len,
  output logic [CW-1:0]     short_len,
  output logic              short_ok
);
  always_comb begin
    if (!kind.wide)     def_len = CW'(LEN_X8);
    else if (kind.mem)  def_len = CW'(LEN_M16);
    else                def_len = CW'(LEN_IO16);
    short_len = (kind.wide) ? CW'(SHORT_M16) : CW'(SHORT_X8);
    short_ok  = kind.mem || !kind.wide;
  end
endmodule

// File: rtl/isa_cmd_fsm.sv
module isa_cmd_fsm
  import isa_cyc_pkg::*;
#(
  parameter int AW       = 20,
  parameter int DW       = 8,
  parameter int CW       = 5,
  parameter int SW       = 5,
  parameter int TMO_BCLK = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_rst,
  input  logic          req,
  input  cyc_kind_t     kind_in,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          zws_n,
  input  logic          chrdy,
  input  logic [DW-1:0] sd_in,
  input  logic [CW-1:0] def_len,
  input  logic [CW-1:0] short_len,
  input  logic          short_ok,
  output logic          active,
  output cyc_kind_t     kind_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          ack,
  output logic          ack_err,
  output logic [DW-1:0] rdata
);
  localparam logic [SW-1:0] STALL_LAST = SW'(TMO_BCLK - 1);

  cyc_state_e    st_q, st_d;
  logic [CW-1:0] k_q, k_d, k_next;
  logic [SW-1:0] stl_q, stl_d;
  cyc_kind_t     kind_d;
  logic [AW-1:0] addr_d;
  logic [DW-1:0] wdata_d, rdata_d;
  logic          ack_d, err_d, finish;

  always_comb begin
    st_d    = st_q;
    k_d     = k_q;
    stl_d   = stl_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    rdata_d = rdata;
    ack_d   = 1'b0;
    err_d   = 1'b0;
    finish  = 1'b0;
    k_next  = k_q + 1'b1;
    if (bus_rst) begin
      st_d = ST_IDLE;
    end else if (tick) begin
      case (st_q)
        ST_IDLE: if (req) begin
          st_d    = ST_CMD;
          kind_d  = kind_in;
          addr_d  = addr_in;
          wdata_d = wdata_in;
          k_d     = '0;
          stl_d   = '0;
        end
        default: begin
          k_d = k_next;
          if (!chrdy) begin
            // ready low blocks both shortening and normal completion
            if (stl_q == STALL_LAST) begin
              finish = 1'b1;
              err_d  = 1'b1;
            end else begin
              stl_d = stl_q + 1'b1;
            end
          end else if (!zws_n && short_ok && (k_next >= short_len)) begin
            finish = 1'b1;
          end else if (k_next >= def_len) begin
            finish = 1'b1;
          end
          if (finish) begin
            st_d  = ST_IDLE;
            ack_d = 1'b1;
            if (!kind_q.write) rdata_d = sd_in;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      k_q     <= '0;
      stl_q   <= '0;
      kind_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      ack     <= 1'b0;
      ack_err <= 1'b0;
    end else begin
      st_q    <= st_d;
      k_q     <= k_d;
      stl_q   <= stl_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata   <= rdata_d;
      ack     <= ack_d;
      ack_err <= err_d;
    end
  end

  assign active = (st_q == ST_CMD);
endmodule

// File: rtl/isa_cycle_ctl.sv
module isa_cycle_ctl
  import isa_cyc_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 8,
  parameter int DIV_LOG2  = 2,
  parameter int LEN_M16   = 3,
  parameter int LEN_X8    = 6,
  parameter int LEN_IO16  = 3,
  parameter int SHORT_M16 = 2,
  parameter int SHORT_X8  = 3,
  parameter int TMO_BCLK  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rst,
  input  logic          req,
  input  logic          req_mem,
  input  logic          req_wide,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          ack,
  output logic          ack_err,
  output logic [DW-1:0] ack_rdata,
  output logic          bus_clk,
  output logic [AW-1:0] bus_addr,
  output logic          memr_n,
  output logic          memw_n,
  output logic          ior_n,
  output logic          iow_n,
  input  logic          zws_n,
  input  logic          chrdy,
  input  logic [DW-1:0] sd_in,
  output logic [DW-1:0] sd_out,
  output logic          sd_oe
);
  localparam int MAXK = LEN_M16 + LEN_X8 + LEN_IO16 + TMO_BCLK;
  localparam int CW   = $clog2(MAXK + 1);
  localparam int SW   = $clog2(TMO_BCLK + 1);

  logic          tick, active, short_ok;
  logic [CW-1:0] def_len, short_len;
  cyc_kind_t     kind_in, kind_q;
  logic [DW-1:0] wdata_q;

  assign kind_in = '{mem: req_mem, wide: req_wide, write: req_write};

  isa_bclk_div #(.DIV_LOG2(DIV_LOG2)) i_div (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .tick(tick)
  );

  isa_len_sel #(
    .CW(CW), .LEN_M16(LEN_M16), .LEN_X8(LEN_X8), .LEN_IO16(LEN_IO16),
    .SHORT_M16(SHORT_M16), .SHORT_X8(SHORT_X8)
  ) i_len (
    .kind(kind_q), .def_len(def_len), .short_len(short_len), .short_ok(short_ok)
  );

  isa_cmd_fsm #(
    .AW(AW), .DW(DW), .CW(CW), .SW(SW), .TMO_BCLK(TMO_BCLK)
  ) i_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_rst(bus_rst), .req(req),
    .kind_in(kind_in), .addr_in(req_addr), .wdata_in(req_wdata),
    .zws_n(zws_n), .chrdy(chrdy), .sd_in(sd_in),
    .def_len(def_len), .short_len(short_len), .short_ok(short_ok),
    .active(active), .kind_q(kind_q), .addr_q(bus_addr), .wdata_q(wdata_q),
    .ack(ack), .ack_err(ack_err), .rdata(ack_rdata)
  );

  always_comb begin
    memr_n = !(active &&  kind_q.mem && !kind_q.write);
    memw_n = !(active &&  kind_q.mem &&  kind_q.write);
    ior_n  = !(active && !kind_q.mem && !kind_q.write);
    iow_n  = !(active && !kind_q.mem &&  kind_q.write);
  end

  assign sd_out = wdata_q;
  assign sd_oe  = active && kind_q.write && !bus_rst;
endmodule

// File: rtl/isa_cycle_ctl_chk.sv
module isa_cycle_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_rst,
  input logic bus_clk,
  input logic memr_n,
  input logic memw_n,
  input logic ior_n,
  input logic iow_n,
  input logic sd_oe,
  input logic ack,
  input logic ack_err
);
  logic [3:0] strb;
  assign strb = ~{memr_n, memw_n, ior_n, iow_n};

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb));

  a_r10_strobe_on_bus_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(strb) && !$past(bus_rst)) |-> $rose(bus_clk));

  a_r1_high_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_clk) |=> bus_clk);

  a_r1_low_two: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_clk) |=> !bus_clk);

  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  a_r9_ack_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ((strb == 4'b0000) && ($past(strb) != 4'b0000)));

  a_r8_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_err |-> ack);

  a_r11_quiet_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> ((strb == 4'b0000) && !sd_oe));
endmodule

bind isa_cycle_ctl isa_cycle_ctl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_clk(bus_clk),
  .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
  .sd_oe(sd_oe), .ack(ack), .ack_err(ack_err)
);

// File: tb/test_isa_cycle_ctl.sv
`timescale 1ns/1ps
module test_isa_cycle_ctl;
  localparam int AW  = 20;
  localparam int DW  = 8;
  localparam int TMO = 16;

  logic clk, rst_n, bus_rst, req, req_mem, req_wide, req_write;
  logic [AW-1:0] req_addr, bus_addr;
  logic [DW-1:0] req_wdata, ack_rdata, sd_in, sd_out;
  logic ack, ack_err, bus_clk, memr_n, memw_n, ior_n, iow_n, zws_n, chrdy, sd_oe;

  int checks = 0, failures = 0, cyc = 0;
  int low_cnt, zmode, stall_s;
  logic [3:0] seen_mask;
  bit bus_bad;
  logic [AW-1:0] exp_addr;
  logic [DW-1:0] exp_wd;
  bit exp_wr;

  isa_cycle_ctl #(.AW(AW), .DW(DW), .TMO_BCLK(TMO)) i_isa_cycle_ctl (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave model and bus monitor
  always @(negedge clk) begin
    logic [3:0] s;
    s = ~{memr_n, memw_n, ior_n, iow_n};
    if (s != 4'b0000) begin
      low_cnt++;
      seen_mask |= s;
      if (bus_addr != exp_addr) bus_bad = 1'b1;
      if (exp_wr && (!sd_oe || sd_out != exp_wd)) bus_bad = 1'b1;
      chrdy = ((low_cnt - 1) / 4) >= stall_s;
      zws_n = (zmode == 1) ? 1'b0 : 1'b1;
    end else begin
      chrdy = 1'b1;
      zws_n = (zmode == 0) ? 1'b1 : 1'b0;
    end
  end

  function automatic void exp_cycle(input bit mem, input bit wide, input bit zon, input int s,
                                    output int len, output bit err);
    int def, sh, stl;
    bit ok;
    def = wide ? 3 : 6;
    sh  = (mem && wide) ? 2 : 3;
    ok  = mem || !wide;
    stl = 0;
    err = 0;
    len = 0;
    for (int k = 1; k < 200; k++) begin
      if (k <= s) begin
        stl++;
        if (stl == TMO) begin len = k; err = 1; return; end
      end else if ((zon && ok && k >= sh) || k >= def) begin
        len = k;
        return;
      end
    end
  endfunction

  task automatic run_cycle(input bit mem, input bit wide, input bit wr, input int zm, input int s);
    int elen, wait_n;
    bit eerr;
    string tag;
    logic [DW-1:0] rd;
    logic [3:0] emask;
    exp_cycle(mem, wide, zm == 1, s, elen, eerr);
    if (eerr) tag = "R8";
    else if (s > 0) tag = "R6";
    else if (zm == 2) tag = "R7";
    else if (zm == 1 && !mem && wide) tag = "R4";
    else if (zm == 1 && mem && wide) tag = "R2";
    else if (zm == 1) tag = "R3";
    else tag = "R5";
    emask = mem ? (wr ? 4'b0100 : 4'b1000) : (wr ? 4'b0001 : 4'b0010);
    @(negedge clk);
    rd = DW'($urandom);
    sd_in = rd;
    zmode = zm; stall_s = s; low_cnt = 0; seen_mask = '0; bus_bad = 0;
    exp_addr = AW'($urandom); exp_wd = DW'($urandom); exp_wr = wr;
    req = 1; req_mem = mem; req_wide = wide; req_write = wr;
    req_addr = exp_addr; req_wdata = exp_wd;
    wait_n = 0;
    while (!ack && wait_n < 1000) begin @(negedge clk); wait_n++; end
    req = 0;
    chk({tag, " strobe length (bus clocks)"}, low_cnt == 4 * elen, low_cnt / 4, elen);
    chk("R8 ack_err", ack_err == eerr, ack_err, eerr);
    chk("R10 strobe select", seen_mask == emask, seen_mask, emask);
    chk("R10 address/write data on bus", !bus_bad, bus_bad, 0);
    if (!wr) chk("R9 read data", ack_rdata == rd, ack_rdata, rd);
    @(negedge clk);
    chk("R9 ack one clock", ack == 1'b0, ack, 0);
    zmode = 0;
  endtask

  initial begin
    int rises, highs;
    process::self().srandom(32'd7);
    rst_n = 0; bus_rst = 0; req = 0; req_mem = 0; req_wide = 0; req_write = 0;
    req_addr = '0; req_wdata = '0; sd_in = '0; zws_n = 1; chrdy = 1;
    zmode = 0; stall_s = 0; low_cnt = 0; seen_mask = '0; bus_bad = 0;
    exp_addr = '0; exp_wd = '0; exp_wr = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 strobes idle", {memr_n, memw_n, ior_n, iow_n} == 4'hF, {memr_n, memw_n, ior_n, iow_n}, 15);
    chk("R12 ack low", ack == 0, ack, 0);
    chk("R12 sd_oe low", sd_oe == 0, sd_oe, 0);

    // R1 divider
    rises = 0; highs = 0;
    for (int i = 0; i < 40; i++) begin
      logic prev;
      prev = bus_clk;
      @(negedge clk);
      if (bus_clk && !prev) rises++;
      if (bus_clk) highs++;
    end
    chk("R1 bus_clk rises in 40 clk", rises == 10, rises, 10);
    chk("R1 bus_clk duty", highs == 20, highs, 20);

    // directed: defaults R5
    run_cycle(1, 1, 0, 0, 0);
    run_cycle(1, 0, 1, 0, 0);
    run_cycle(0, 0, 0, 0, 0);
    run_cycle(0, 1, 1, 0, 0);
    // shortening R2 R3 R4
    run_cycle(1, 1, 1, 1, 0);
    run_cycle(1, 0, 0, 1, 0);
    run_cycle(0, 0, 1, 1, 0);
    run_cycle(0, 1, 0, 1, 0);
    // idle-only shortening R7
    run_cycle(1, 1, 0, 2, 0);
    run_cycle(0, 0, 0, 2, 0);
    // ready overrides shortening R6
    run_cycle(1, 1, 0, 1, 2);
    run_cycle(0, 0, 1, 1, 4);
    run_cycle(1, 0, 0, 0, 7);
    // timeout R8, then a normal cycle to show stall count cleared
    run_cycle(1, 0, 0, 1, TMO + 3);
    run_cycle(0, 0, 0, 0, TMO - 1);

    // R11 bus reset mid-cycle
    begin
      bit acked;
      int w;
      @(negedge clk);
      zmode = 0; stall_s = 0; exp_wr = 1; exp_wd = 8'h5A; exp_addr = 'h123;
      req = 1; req_mem = 1; req_wide = 0; req_write = 1; req_addr = exp_addr; req_wdata = exp_wd;
      w = 0;
      while (memw_n && w < 100) begin @(negedge clk); w++; end
      bus_rst = 1; req = 0;
      @(negedge clk);
      chk("R11 strobes idle in bus reset", {memr_n, memw_n, ior_n, iow_n} == 4'hF,
          {memr_n, memw_n, ior_n, iow_n}, 15);
      chk("R11 sd_oe low in bus reset", sd_oe == 0, sd_oe, 0);
      rises = 0; acked = 0;
      for (int i = 0; i < 16; i++) begin
        logic prev;
        prev = bus_clk;
        @(negedge clk);
        if (bus_clk && !prev) rises++;
        if (ack) acked = 1;
      end
      chk("R1 bus_clk runs in bus reset", rises == 4, rises, 4);
      bus_rst = 0;
      repeat (12) begin @(negedge clk); if (ack) acked = 1; end
      chk("R11 dropped cycle no ack", !acked, acked, 0);
    end

    // constrained random
    for (int n = 0; n < 40; n++) begin
      int s, zm;
      s  = ($urandom % 4 == 0) ? int'($urandom % 20) : 0;
      zm = int'($urandom % 3);
      run_cycle(1'($urandom), 1'($urandom), 1'($urandom), zm, s);
    end
    finish_run();
  end
endmodule